// File: doc/BRIEF.md
# Receive Path Fault Flag Register with Interrupt

This block collects seven one-cycle event pulses from a receive datapath and holds each of them in a sticky flag until the host reads the flag register. Six of the pulses report overflow faults: from the I and Q outputs of the gain/phase/offset correction stage, from the I and Q converters, from the low-pass filter accumulator and from the root-raised-cosine filter accumulator. The seventh is a marker that fires on Q-phase output samples. The host can use this marker to realign to the I/Q framing. After the host has realigned, it masks the marker again.

A separate enable register selects which held flags may pull the active-low interrupt line. A summary bit in the flag register reports whether any enabled flag is driving the interrupt. The summary is not latched, so it tracks the flags and enables from cycle to cycle. The host reaches both registers through a single-cycle read/write strobe interface with a 7-bit address. Read data is registered, so it appears on the cycle after the strobe and shows the flags as they were before that read cleared them.

Top module: `rx_fault_irq_reg`

## Requirements
- R1: After reset every held flag is 0, the enable register is 0, and `irq_n_o` is high.
- R2: A pulse on `evt_i[k]` sets flag register bit k+1. The bits are, from bit 7 down: correction-stage Q overflow, correction-stage I overflow, converter Q overflow, converter I overflow, low-pass accumulator overflow, RRC accumulator overflow, Q-phase marker.
- R3: A read strobe at address 0x20 returns the pre-clear flag value on `reg_rdata_o` in the following cycle, with the summary in bit 0.
- R4: A read at 0x20 clears every held flag whose event input is low in the cycle of the read.
- R5: A flag whose event input is high in the cycle of a clearing read is set after that read, so no event is lost.
- R6: `irq_n_o` is low exactly when some held flag k+1 has enable bit k+1 set (1 = enabled).
- R7: Flag register bit 0 equals the OR of the enabled held flags. It drops as soon as those flags clear or are masked.
- R8: The enable register sits at address 0x21 and can be read and written. Bits 7:1 are stored and bit 0 always reads 0.
- R9: A write to 0x20 changes neither the flags nor the enable register.
- R10: A read at any other address returns 0 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 7 | One-cycle event pulses, bit k sets flag bit k+1 |
| reg_addr_i | input | 7 | Register address |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is an event that lands in the same cycle as the read that clears the register. In that cycle the read must return the old flags while the new event must still be set afterwards. The bench drives the event vector and the read strobe on the same falling edge. It sweeps every pair of old pattern and colliding pattern that it uses. It then reads twice to observe the surviving set and the fully cleared set. It repeats the sweep over all 128 event patterns under several enable patterns, so that the summary and interrupt are compared against the OR of the pattern with the enable.

// File: rtl/rx_fault_pkg.sv
// Shared constants and types for the receive fault flag register.
// Assumes a 7-bit register address space and single-cycle strobes.
package rx_fault_pkg;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int NUM_SRC  = DATA_W - 1;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 7'h20;
    localparam logic [ADDR_W-1:0] ENAB_ADDR = 7'h21;

    // Decoded host access for one cycle.
    typedef struct packed {
        logic rd_flag;
        logic rd_enab;
        logic wr_enab;
    } access_t;
endpackage

// File: rtl/rx_fault_decode.sv
// Address decoder: turns strobes and address into one-hot access requests.
// Assumes read and write are not asserted together; if they are, both act.
// Writes to the flag address decode to nothing, so they are dropped.
module rx_fault_decode
    import rx_fault_pkg::*;
#(
    parameter logic [ADDR_W-1:0] P_FLAG_ADDR = FLAG_ADDR,
    parameter logic [ADDR_W-1:0] P_ENAB_ADDR = ENAB_ADDR
) (
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output access_t           acc_o
);
    // Compare address against each register.
    always_comb begin
        acc_o.rd_flag = rd_i && (addr_i == P_FLAG_ADDR);
        acc_o.rd_enab = rd_i && (addr_i == P_ENAB_ADDR);
        acc_o.wr_enab = wr_i && (addr_i == P_ENAB_ADDR);
    end
endmodule

// File: rtl/rx_fault_sticky.sv
// Bank of sticky flags, one per event source.
// A flag is set by its event and cleared by a read, but a same-cycle
// event wins over the clear, so an event is never lost.
module rx_fault_sticky #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] held_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        // Hold one flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held_o[k] <= 1'b0;
            else if (evt_i[k])
                held_o[k] <= 1'b1;
            else if (clr_i)
                held_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_fault_enable.sv
// Interrupt enable register, 1 = flag may drive the interrupt.
// Assumes the write data bit 0 is a don't-care (summary position).
module rx_fault_enable #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N:0]   wdata_i,
    output logic [N-1:0] en_o
);
    // Capture enable bits from the upper write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_i)
            en_o <= wdata_i[N:1];
    end
endmodule

// File: rtl/rx_fault_irq_reg.sv
// Receive fault flag register with masked active-low interrupt.
// Assumes event inputs are synchronous to clk. Read data is registered
// and shows the state sampled at the read strobe edge (before clear).
module rx_fault_irq_reg
    import rx_fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_n_o
);
    access_t            acc;
    logic [NUM_SRC-1:0] held;
    logic [NUM_SRC-1:0] en;
    logic               summary;

    rx_fault_decode u_dec (
        .rd_i   (reg_rd_i),
        .wr_i   (reg_wr_i),
        .addr_i (reg_addr_i),
        .acc_o  (acc)
    );

    rx_fault_sticky #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (acc.rd_flag),
        .held_o (held)
    );

    rx_fault_enable #(.N(NUM_SRC)) u_enab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (acc.wr_enab),
        .wdata_i (reg_wdata_i),
        .en_o    (en)
    );

    // Unlatched summary of enabled flags.
    always_comb summary = |(held & en);

    // Active-low interrupt follows the summary.
    always_comb irq_n_o = ~summary;

    // Register read data from the pre-clear state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata_o <= '0;
        else if (acc.rd_flag)
            reg_rdata_o <= {held, summary};
        else if (acc.rd_enab)
            reg_rdata_o <= {en, 1'b0};
        else if (reg_rd_i)
            reg_rdata_o <= '0;
    end
endmodule

// File: rtl/rx_fault_irq_chk.sv
// Checker bound to rx_fault_irq_reg: relates strobes, events, flags,
// enables, read data and interrupt across cycles.
module rx_fault_irq_chk
    import rx_fault_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic               reg_rd_i,
    input logic               reg_wr_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_n_o,
    input logic [NUM_SRC-1:0] held,
    input logic [NUM_SRC-1:0] en
);
    // R3
    flag_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == FLAG_ADDR) |=> reg_rdata_o[DATA_W-1:1] == $past(held));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == FLAG_ADDR) |=> held == $past(evt_i));

    // R5
    no_event_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((held & $past(evt_i)) == $past(evt_i)));

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> ($past(evt_i) != '0 || $past(reg_wr_i)));

    // R9
    flag_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == FLAG_ADDR && !reg_rd_i)
        |=> (held == ($past(held) | $past(evt_i))) && $stable(en));
endmodule

bind rx_fault_irq_reg rx_fault_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_n_o     (irq_n_o),
    .held        (held),
    .en          (en)
);

// File: tb/rx_fault_irq_reg_tb_top.sv
// Sweeping bench for rx_fault_irq_reg; expected values computed here.
module rx_fault_irq_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt = '0;
    logic [6:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rx_fault_irq_reg dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_n_o(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read strobe for one cycle, optional colliding events; data valid after.
    task automatic reg_read(input logic [6:0] a, input logic [6:0] coll, output logic [7:0] d);
        addr = a; rd = 1'b1; evt = coll;
        @(negedge clk);
        rd = 1'b0; evt = '0;
        d = rdata;
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [7:0] d);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] p);
        evt = p;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        logic [7:0] d;
        logic [6:0] masks [4] = '{7'h7F, 7'h00, 7'h55, 7'h2A};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {7'd0, irq_n}, 8'h01);
        reg_read(7'h20, '0, d); check("R1 flags", d, 8'h00);
        reg_read(7'h21, '0, d); check("R1 enable", d, 8'h00);

        // R8 enable readback, bit 0 reads 0
        reg_write(7'h21, 8'hFF);
        reg_read(7'h21, '0, d); check("R8", d, 8'hFE);
        reg_write(7'h21, 8'h5B);
        reg_read(7'h21, '0, d); check("R8", d, 8'h5A);

        // R9 writes to flag address ignored
        pulse(7'h15);
        reg_write(7'h20, 8'h00);
        reg_write(7'h20, 8'hFF);
        reg_read(7'h21, '0, d); check("R9 enable", d, 8'h5A);
        reg_read(7'h20, '0, d); check("R9 flags", d, {7'h15, |(7'h15 & 7'h2D)});

        // R10 other addresses read 0, no clear
        pulse(7'h40);
        reg_read(7'h05, '0, d); check("R10 data", d, 8'h00);
        reg_read(7'h22, '0, d); check("R10 data", d, 8'h00);
        reg_read(7'h20, '0, d); check("R10 kept", d, {7'h40, 1'b0});

        // R2 R3 R4 R6 R7 sweep all patterns under several enables
        foreach (masks[mi]) begin
            reg_write(7'h21, {masks[mi], 1'b0});
            for (int p = 0; p < 128; p++) begin
                logic s;
                s = |(p[6:0] & masks[mi]);
                pulse(p[6:0]);
                check("R6 irq", {7'd0, irq_n}, {7'd0, ~s});
                reg_read(7'h20, '0, d); check("R2 R3 R7 read", d, {p[6:0], s});
                check("R6 irq after clear", {7'd0, irq_n}, 8'h01);
                reg_read(7'h20, '0, d); check("R4 cleared", d, 8'h00);
            end
        end

        // R7 summary drops on masking without a read
        reg_write(7'h21, 8'hFE);
        pulse(7'h01);
        check("R7 irq on", {7'd0, irq_n}, 8'h00);
        reg_write(7'h21, 8'h00);
        check("R7 irq masked", {7'd0, irq_n}, 8'h01);
        reg_read(7'h20, '0, d); check("R7 summary masked", d, 8'h02);

        // R5 events colliding with a clearing read survive
        reg_write(7'h21, 8'hFE);
        for (int p = 0; p < 128; p += 9) begin
            logic [6:0] q;
            q = p[6:0] ^ 7'h2A;
            pulse(p[6:0]);
            reg_read(7'h20, q, d); check("R5 old", d, {p[6:0], |p[6:0]});
            check("R5 irq", {7'd0, irq_n}, {7'd0, ~|q});
            reg_read(7'h20, '0, d); check("R5 kept", d, {q, |q});
            reg_read(7'h20, '0, d); check("R5 cleared", d, 8'h00);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule